// File: doc/BRIEF.md
# AES Final-Round Byte Step Unit

This unit carries out a single byte step of the last AES encryption round on integer register operands. It takes one byte out of the second source word at a lane picked by a 2-bit selector. It passes that byte through the forward AES substitution box and puts the substituted byte back at the same lane, with zeros in the other lanes. It then XORs this word with the low 32 bits of the first source. The 32-bit result can be sign-extended to the full register width. The last-round mixing step is not applied.

Software chains four of these steps, one per lane, to finish one column of a final round. Each step feeds the accumulated word back in as the first source. Operations enter through a valid/ready handshake. Every result appears after exactly one register stage, whatever the data. A new operation can be accepted on every cycle unless the consumer stalls.

Top module: `aes_final_byte_step`

## Requirements
- R1: The selector `in_bsel` (value 0 to 3) picks byte `in_rs2[8*bsel+7 : 8*bsel]` as the substitution input.
- R2: The substitution is the exact forward AES S-box, never the inverse one. For example 0x00 maps to 0x63, 0x53 to 0xED, 0x01 to 0x7C and 0xFF to 0x16.
- R3: Bits 31..0 of the result equal `in_rs1[31:0] XOR (S(byte) << 8*bsel)`. The other three byte lanes of the shifted word are zero.
- R4: With `in_wide`=1, result bits XLEN-1..32 all equal result bit 31. With `in_wide`=0 they are zero.
- R5: Bits above 31 of `in_rs1` and `in_rs2` have no effect on the result.
- R6: A transfer accepted at clock edge k (`in_valid` and `in_ready` both high) shows `out_valid`=1 and its result after edge k. This latency is the same for every operand value.
- R7: While `out_valid`=1 and `out_ready`=0, `out_result` and `out_valid` hold steady and `in_ready` is 0.
- R8: Synchronous active-high `rst` clears `out_valid` at the next edge, which leaves `in_ready`=1.
- R9: With `out_ready` held at 1, one operation is accepted on every cycle, and results come out in order with no gaps.
- R10: Four chained steps with selectors 0,1,2,3, each using the previous result as `in_rs1`, give `rs1 XOR {S(b3),S(b2),S(b1),S(b0)}`, where bN is byte N of `in_rs2`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_rs1 | input | XLEN | XOR source word (low 32 bits used) |
| in_rs2 | input | XLEN | Byte source word (low 32 bits used) |
| in_bsel | input | 2 | Byte lane selector |
| in_wide | input | 1 | 1: sign-extend result to XLEN, 0: zero upper bits |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | XLEN | Step result |

## Verification
The assertions check the handshake on every cycle: reset clearing the output, the one-stage acceptance latency, holding under stall, blocking of input while stalled, and full throughput when the consumer is ready. Only the bench's scenarios can show the data path. This covers the exhaustive S-box mapping, lane placement for each selector, sign or zero extension, blindness to the upper operand bits, and the four-step column composition.

// File: rtl/afbs_pkg.sv
package afbs_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int SEL_W  = $clog2(LANES);
    localparam logic [BYTE_W-1:0] AFFINE_C = 8'h63;
    localparam logic [BYTE_W-1:0] GF_POLY  = 8'h1B;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SEL_W-1:0]  lane_t;

    typedef enum logic {
        EXT_ZERO = 1'b0,
        EXT_SIGN = 1'b1
    } ext_mode_e;

    typedef struct packed {
        word_t     acc;
        word_t     src;
        lane_t     lane;
        ext_mode_e ext;
    } step_req_t;

    function automatic byte_t gf_xtime(byte_t a);
        return a[BYTE_W-1] ? ((a << 1) ^ GF_POLY) : (a << 1);
    endfunction

    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // a^254 is the multiplicative inverse in GF(2^8); zero maps to zero
    function automatic byte_t gf_inv(byte_t a);
        byte_t res;
        byte_t pw;
        logic [7:0] ex;
        res = 8'h01;
        pw  = a;
        ex  = 8'd254;
        for (int i = 0; i < 8; i++) begin
            if (ex[i]) res = gf_mul(res, pw);
            pw = gf_mul(pw, pw);
        end
        return res;
    endfunction

    function automatic byte_t rotl8(byte_t b, int n);
        return byte_t'((b << n) | (b >> (BYTE_W - n)));
    endfunction

    function automatic byte_t sbox_affine(byte_t b);
        byte_t r;
        r = b;
        for (int k = 1; k <= 4; k++) r = r ^ rotl8(b, k);
        return r ^ AFFINE_C;
    endfunction

    function automatic byte_t sbox_fwd(byte_t x);
        return sbox_affine(gf_inv(x));
    endfunction

endpackage

// File: rtl/afbs_byte_pick.sv
module afbs_byte_pick
    import afbs_pkg::*;
(
    input  word_t word_in,
    input  lane_t lane,
    output byte_t byte_out
);

    always_comb begin
        byte_out = '0;
        for (int l = 0; l < LANES; l++) begin
            if (lane == lane_t'(l)) byte_out = word_in[l*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/afbs_sbox.sv
module afbs_sbox
    import afbs_pkg::*;
(
    input  byte_t sb_in,
    output byte_t sb_out
);

    always_comb sb_out = sbox_fwd(sb_in);

endmodule

// File: rtl/afbs_merge.sv
module afbs_merge
    import afbs_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  byte_t           sub_byte,
    input  lane_t           lane,
    input  word_t           acc,
    input  ext_mode_e       ext,
    output logic [XLEN-1:0] result
);

    word_t placed;
    word_t low_word;

    always_comb begin
        placed = '0;
        for (int l = 0; l < LANES; l++) begin
            if (lane == lane_t'(l)) placed[l*BYTE_W +: BYTE_W] = sub_byte;
        end
        low_word = acc ^ placed;
    end

    generate
        if (XLEN > WORD_W) begin : g_ext
            always_comb begin
                result[WORD_W-1:0]    = low_word;
                result[XLEN-1:WORD_W] = (ext == EXT_SIGN) ? {(XLEN-WORD_W){low_word[WORD_W-1]}}
                                                          : '0;
            end
        end else begin : g_narrow
            logic merge_unused_ext;
            assign merge_unused_ext = ext;
            assign result = low_word;
        end
    endgenerate

endmodule

// File: rtl/afbs_outreg.sv
module afbs_outreg #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [XLEN-1:0] in_data,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [XLEN-1:0] out_data
);

    logic            valid_q;
    logic [XLEN-1:0] data_q;

    assign in_ready  = !valid_q || out_ready;
    assign out_valid = valid_q;
    assign out_data  = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else if (in_ready) begin
            valid_q <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && in_ready && in_valid) data_q <= in_data;
    end

    AST_RST_CLEARS: assert property (@(posedge clk) rst |=> !out_valid); // R8
    AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (rst) (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data))); // R6
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
    AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_ready) |-> !in_ready); // R7
    AST_STREAM_OPEN: assert property (@(posedge clk) disable iff (rst) out_ready |-> in_ready); // R9

endmodule

// File: rtl/aes_final_byte_step.sv
module aes_final_byte_step
    import afbs_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [XLEN-1:0] in_rs1,
    input  logic [XLEN-1:0] in_rs2,
    input  logic [1:0]      in_bsel,
    input  logic            in_wide,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [XLEN-1:0] out_result
);

    step_req_t       req;
    byte_t           picked;
    byte_t           substituted;
    logic [XLEN-1:0] step_value;

    always_comb begin
        req.acc  = in_rs1[WORD_W-1:0];
        req.src  = in_rs2[WORD_W-1:0];
        req.lane = lane_t'(in_bsel);
        req.ext  = in_wide ? EXT_SIGN : EXT_ZERO;
    end

    generate
        if (XLEN > WORD_W) begin : g_hi
            logic top_unused_hi;
            assign top_unused_hi = ^{in_rs1[XLEN-1:WORD_W], in_rs2[XLEN-1:WORD_W]};
        end
    endgenerate

    afbs_byte_pick u_pick (
        .word_in  (req.src),
        .lane     (req.lane),
        .byte_out (picked)
    );

    afbs_sbox u_sbox (
        .sb_in  (picked),
        .sb_out (substituted)
    );

    afbs_merge #(.XLEN(XLEN)) u_merge (
        .sub_byte (substituted),
        .lane     (req.lane),
        .acc      (req.acc),
        .ext      (req.ext),
        .result   (step_value)
    );

    afbs_outreg #(.XLEN(XLEN)) u_outreg (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (step_value),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_result)
    );

endmodule

// File: tb/aes_final_byte_step_tb.sv
module aes_final_byte_step_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [XLEN-1:0] in_rs1 = '0;
    logic [XLEN-1:0] in_rs2 = '0;
    logic [1:0]      in_bsel = '0;
    logic            in_wide = 1'b0;
    logic            out_valid;
    logic            out_ready = 1'b1;
    logic [XLEN-1:0] out_result;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aes_final_byte_step #(.XLEN(XLEN)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_rs1(in_rs1), .in_rs2(in_rs2), .in_bsel(in_bsel), .in_wide(in_wide),
        .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
    );

    // reference model built from the requirements
    function automatic logic [7:0] m_mul(logic [7:0] a, logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (a[i]) p = p ^ (16'(b) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11B << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] m_sbox(logic [7:0] x);
        logic [7:0] inv;
        logic [7:0] s;
        logic [7:0] c;
        inv = 8'h00;
        for (int y = 1; y < 256; y++) if (x != 0 && m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
        c = 8'h63;
        for (int i = 0; i < 8; i++)
            s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
        return s;
    endfunction

    function automatic logic [XLEN-1:0] m_step(logic [XLEN-1:0] a, logic [XLEN-1:0] b,
                                               logic [1:0] sel, logic wide);
        logic [31:0] lo;
        logic [7:0]  bt;
        bt = b[8*sel +: 8];
        lo = a[31:0] ^ (32'(m_sbox(bt)) << (8*sel));
        return wide ? {{(XLEN-32){lo[31]}}, lo} : {{(XLEN-32){1'b0}}, lo};
    endfunction

    task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(string req, logic [XLEN-1:0] a, logic [XLEN-1:0] b,
                         logic [1:0] sel, logic wide, output logic [XLEN-1:0] res);
        @(negedge clk);
        in_valid = 1'b1; in_rs1 = a; in_rs2 = b; in_bsel = sel; in_wide = wide;
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " valid"}, XLEN'(out_valid), XLEN'(1));
        chk(req, out_result, m_step(a, b, sel, wide));
        res = out_result;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset out_valid", XLEN'(out_valid), '0);
        chk("R8 reset in_ready", XLEN'(in_ready), XLEN'(1));
        rst = 1'b0;
    endtask

    task automatic t_known();
        logic [XLEN-1:0] r;
        do_op("R2 sbox 00->63", '0, 64'h0, 2'd0, 1'b0, r);
        chk("R2 known 63", r, 64'h63);
        do_op("R2 sbox 53->ED", '0, 64'h53, 2'd0, 1'b0, r);
        chk("R2 known ED", r, 64'hED);
        do_op("R2 sbox 01->7C", '0, 64'h01, 2'd0, 1'b0, r);
        chk("R2 known 7C", r, 64'h7C);
        do_op("R2 sbox FF->16", '0, 64'hFF, 2'd0, 1'b0, r);
        chk("R2 known 16", r, 64'h16);
    endtask

    task automatic t_exhaustive();
        logic [XLEN-1:0] r;
        for (int v = 0; v < 256; v++) begin
            logic [1:0] sel;
            sel = 2'(v);
            do_op("R2 R6 exhaustive", 64'(32'h9E37_79B9 * v),
                  64'(v) << (8*sel), sel, 1'b0, r);
        end
    endtask

    task automatic t_lanes();
        logic [XLEN-1:0] r;
        for (int s = 0; s < 4; s++) begin
            do_op("R1 R3 lane", 64'h0, 64'h5300_0000_1122_3344 | (64'h53 << (8*s)) & 64'hFFFF_FFFF
                  ^ (64'h1122_3344 & ~(64'hFF << (8*s))), 2'(s), 1'b0, r);
            do_op("R3 xor lane", 64'hA5A5_5A5A, 64'hC3D2_E1F0, 2'(s), 1'b0, r);
        end
    endtask

    task automatic t_ext();
        logic [XLEN-1:0] r;
        do_op("R4 sign neg", 64'h8000_0000, 64'h0, 2'd0, 1'b1, r);
        chk("R4 sign upper", r, 64'hFFFF_FFFF_8000_0063);
        do_op("R4 sign pos", 64'h0000_0001, 64'h0, 2'd0, 1'b1, r);
        chk("R4 pos upper", r, 64'h0000_0000_0000_0062);
        do_op("R4 zero ext", 64'h8000_0000, 64'h0, 2'd0, 1'b0, r);
        chk("R4 zero upper", r, 64'h0000_0000_8000_0063);
        do_op("R4 lane3 sign", 64'h0, 64'h5300_0000, 2'd3, 1'b1, r);
        chk("R4 lane3 value", r, 64'hFFFF_FFFF_ED00_0000);
    endtask

    task automatic t_upper();
        logic [XLEN-1:0] r0;
        logic [XLEN-1:0] r1;
        do_op("R5 base", 64'h0000_0000_1357_9BDF, 64'h0000_0000_0246_8ACE, 2'd2, 1'b1, r0);
        do_op("R5 dirty", 64'hDEAD_BEEF_1357_9BDF, 64'hFACE_CAFE_0246_8ACE, 2'd2, 1'b1, r1);
        chk("R5 upper ignored", r1, r0);
    endtask

    task automatic t_chain();
        logic [XLEN-1:0] acc;
        logic [XLEN-1:0] col;
        logic [31:0] exp;
        acc = 64'h0123_4567_89AB_CDEF;
        col = 64'h0000_0000_1953_ED7C;
        exp = acc[31:0] ^ {m_sbox(col[31:24]), m_sbox(col[23:16]), m_sbox(col[15:8]), m_sbox(col[7:0])};
        for (int s = 0; s < 4; s++) do_op("R10 chain step", acc, col, 2'(s), 1'b0, acc);
        chk("R10 column", acc, 64'(exp));
    endtask

    task automatic t_stream();
        logic [XLEN-1:0] a [6];
        logic [XLEN-1:0] b [6];
        for (int i = 0; i < 6; i++) begin
            a[i] = 64'(32'h1111_1111 * (i + 1));
            b[i] = 64'(32'h2468_ACE0 + 37 * i);
        end
        for (int i = 0; i <= 6; i++) begin
            @(negedge clk);
            out_ready = 1'b1;
            if (i > 0) begin
                chk("R9 stream valid", XLEN'(out_valid), XLEN'(1));
                chk("R9 stream data", out_result, m_step(a[i-1], b[i-1], 2'(i-1), 1'b1));
            end
            if (i < 6) begin
                chk("R9 stream ready", XLEN'(in_ready), XLEN'(1));
                in_valid = 1'b1; in_rs1 = a[i]; in_rs2 = b[i]; in_bsel = 2'(i); in_wide = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic t_stall();
        logic [XLEN-1:0] held;
        @(negedge clk);
        in_valid = 1'b1; in_rs1 = 64'h0F0F_0F0F; in_rs2 = 64'h0000_5300; in_bsel = 2'd1; in_wide = 1'b0;
        out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        held = m_step(64'h0F0F_0F0F, 64'h0000_5300, 2'd1, 1'b0);
        chk("R7 stall first", out_result, held);
        in_rs1 = 64'hFFFF_0000; in_rs2 = 64'h0000_00FF; in_bsel = 2'd0;
        chk("R7 stall in_ready", XLEN'(in_ready), '0);
        @(posedge clk);
        @(negedge clk);
        chk("R7 stall hold valid", XLEN'(out_valid), XLEN'(1));
        chk("R7 stall hold data", out_result, held);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 release next", out_result, m_step(64'hFFFF_0000, 64'h0000_00FF, 2'd0, 1'b0));
        @(posedge clk);
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        in_valid = 1'b1; out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 pre reset valid", XLEN'(out_valid), XLEN'(1));
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R8 mid reset valid", XLEN'(out_valid), '0);
        chk("R8 mid reset ready", XLEN'(in_ready), XLEN'(1));
        out_ready = 1'b1;
    endtask

    initial begin
        t_reset();
        t_known();
        t_lanes();
        t_ext();
        t_upper();
        t_chain();
        t_stream();
        t_stall();
        t_mid_reset();
        t_exhaustive();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule